// File: doc/BRIEF.md
# MSI Capability Controller

This block holds the message-signalled interrupt capability registers of one PCI function. It turns the function's internal interrupt requests into outgoing memory-write messages, each an address and a data word. Software programs the block through a small config-space window. Each access selects a dword of the capability, and each byte lane of a write has its own enable. A separate request port carries a vector number. Messages leave the block on a valid/ready port and stay stable until the consumer accepts them.

Three build-time parameters shape the capability. They set the vector capacity (a power of two from 1 to 32), whether the address is 64 bits wide, and whether each vector has its own mask. When masking is built in, a request on a masked vector is held as pending and is sent once software unmasks the vector. While MSI is enabled, the legacy level interrupt is forced inactive.

Dword map (index on `cfgAddr`): 0 is the header and message control, 1 is address low, 2 is address high (64-bit build only), then data, then mask, then pending. The data, mask and pending dwords sit one dword higher in the 64-bit build.

Top module: `msi_cap_ctrl`

## Requirements
- R1: After reset, enable, Multiple Message Enable, both address dwords, data, mask and pending are all zero, and `msgValid` is low. With the default parameters, dword 0 reads 0x01840005.
- R2: Dword 0 layout:
  - bits 7:0 read 0x05; bits 15:8 and 31:25 read zero;
  - bit 16 is the enable and bits 22:20 are Multiple Message Enable (MME); these are the only writable bits;
  - bits 19:17 read log2 of the capacity;
  - bit 23 reads the 64-bit option and bit 24 reads the masking option.
  Each byte lane is written only when its byte enable is set.
- R3: Address-low bits 1:0 always read zero. Address high is fully writable in the 64-bit build and absent otherwise. The data dword keeps only bits 15:0, and its upper half reads zero.
- R4: Only mask bits 0 to capacity−1 are writable; the other mask bits read zero. The pending dword ignores writes.
- R5: A control write that leaves the enable set with an MME value above the capable value stores the capable value instead.
- R6: A message address is {address high, address low}, or {32'h0, address low} in the 32-bit build. The message data has upper 16 bits zero. Its low 16 bits are the programmed data with the low MME bits replaced by the vector number; with MME = 0 they are the data unchanged.
- R7: An accepted request on a masked vector sends no message and sets that vector's pending bit. A second request on a vector that is already pending or queued adds nothing.
- R8: When pending vectors become unmasked, each is sent once and its pending bit is cleared. When several are eligible, the lowest-numbered is sent first, one per accepted handshake.
- R9: A config write into the capability that leaves MSI enabled discards queued and pending vectors at or above 2^MME.
- R10: A request while MSI is disabled is dropped and sets no pending bit. A request whose vector is at or above 2^MME is also dropped.
- R11: `intxOut` equals `intxIn` while MSI is disabled and is low while MSI is enabled.
- R12: While `msgValid` is high and `msgReady` is low, `msgValid`, `msgAddr` and `msgData` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 3 | Dword index within the capability |
| cfgByteEn | input | 4 | Byte-lane enables for writes |
| cfgWrData | input | 32 | Config write data |
| cfgRdData | output | 32 | Config read data for `cfgAddr` (combinational) |
| irqValid | input | 1 | Interrupt request strobe |
| irqVec | input | 5 | Vector number of the request |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message consumer accepts |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| intxIn | input | 1 | Legacy interrupt request from the function |
| intxOut | output | 1 | Legacy interrupt request toward the bus |

## Verification
Several properties are checked by assertions on every cycle:
- a launched vector is never masked and is the lowest eligible one;
- the queue never holds a vector outside the enabled count;
- MME never exceeds the capable value while enabled;
- nothing is queued while disabled;
- a stalled message does not change.

Other behaviours can only be shown by the bench's scenarios: register layout and byte lanes, the data merge for each vector count, that a duplicate request produces a single message, the replay order on unmask, trimming when the vector count shrinks, and the legacy-interrupt gating.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int VEC_W = 5;

  // Strobe from the scheduler to the register datapath
  typedef struct packed {
    logic             launch;
    logic [VEC_W-1:0] vec;
  } sendCmdT;

  function automatic logic [31:0] byteMerge(logic [31:0] oldW, logic [31:0] newW, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? newW[b*8 +: 8] : oldW[b*8 +: 8];
    return r;
  endfunction

  // Bits 0 .. 2^mme-1 set
  function automatic logic [31:0] vecCountMask(logic [2:0] mme);
    if (mme >= 3'd5) return 32'hFFFF_FFFF;
    return (32'h1 << (32'h1 << mme)) - 32'h1;
  endfunction
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int VEC_CAP = 4,
  parameter bit ADDR64  = 1'b1,
  parameter bit MASK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgAddr,
  input  logic [3:0]         cfgByteEn,
  input  logic [31:0]        cfgWrData,
  output logic [31:0]        cfgRdData,
  input  logic               reqValid,
  input  logic [VEC_W-1:0]   reqVec,
  input  sendCmdT            cmd,
  output logic               msiEnable,
  output logic [VEC_CAP-1:0] eligible,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData
);
  localparam logic [2:0]  MMC_VAL  = 3'($clog2(VEC_CAP));
  localparam logic [31:0] CAP_BITS = (VEC_CAP >= 32) ? 32'hFFFF_FFFF : ((32'h1 << VEC_CAP) - 32'h1);
  localparam logic [2:0]  IDX_CTRL = 3'd0;
  localparam logic [2:0]  IDX_ALO  = 3'd1;
  localparam logic [2:0]  IDX_AHI  = 3'd2;
  localparam logic [2:0]  IDX_DATA = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0]  IDX_MASK = IDX_DATA + 3'd1;
  localparam logic [2:0]  IDX_PEND = IDX_DATA + 3'd2;
  localparam logic [2:0]  IDX_LAST = MASK_EN ? IDX_PEND : IDX_DATA;
  localparam logic [7:0]  CAP_ID   = 8'h05;

  logic        enReg;
  logic [2:0]  mmeReg;
  logic [31:0] addrLo, addrHi, maskReg, reqQ;
  logic [15:0] dataReg;
  logic [63:0] msgAddrR;
  logic [31:0] msgDataR;

  logic [31:0] ctrlWord, wrWord, maskEff, qNext, inRange;
  logic        enNext, wrHit;
  logic [2:0]  mmeNext;
  logic [15:0] lowMask, launchData;

  assign maskEff  = MASK_EN ? maskReg : 32'h0;
  assign ctrlWord = {7'b0, 1'(MASK_EN), 1'(ADDR64), mmeReg, MMC_VAL, enReg, 8'h00, CAP_ID};
  assign inRange  = vecCountMask(mmeReg);

  // Read mux (also the base for byte-lane merging on writes)
  always_comb begin
    cfgRdData = 32'h0;
    if (cfgAddr == IDX_CTRL) cfgRdData = ctrlWord;
    if (cfgAddr == IDX_ALO) cfgRdData = addrLo;
    if (ADDR64 && cfgAddr == IDX_AHI) cfgRdData = addrHi;
    if (cfgAddr == IDX_DATA) cfgRdData = {16'h0, dataReg};
    if (MASK_EN && cfgAddr == IDX_MASK) cfgRdData = maskReg;
    if (MASK_EN && cfgAddr == IDX_PEND) cfgRdData = reqQ & maskEff;
  end

  assign wrWord = byteMerge(cfgRdData, cfgWrData, cfgByteEn);
  assign wrHit  = cfgWrEn && (cfgAddr <= IDX_LAST);

  // Control next state with clamp of an oversized vector count
  always_comb begin
    enNext  = enReg;
    mmeNext = mmeReg;
    if (cfgWrEn && cfgAddr == IDX_CTRL) begin
      enNext  = wrWord[16];
      mmeNext = wrWord[22:20];
      if (enNext && mmeNext > MMC_VAL) mmeNext = MMC_VAL;
    end
  end

  // Request queue: masked entries are the visible pending bits
  always_comb begin
    qNext = reqQ;
    if (cmd.launch) qNext[cmd.vec] = 1'b0;
    if (reqValid && enReg && inRange[reqVec]) qNext[reqVec] = 1'b1;
    if (wrHit && enNext) qNext = qNext & vecCountMask(mmeNext);
    qNext = qNext & CAP_BITS;
  end

  assign lowMask    = (16'h1 << mmeReg) - 16'h1;
  assign launchData = (dataReg & ~lowMask) | (16'(cmd.vec) & lowMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      mmeReg   <= 3'd0;
      addrLo   <= 32'h0;
      addrHi   <= 32'h0;
      dataReg  <= 16'h0;
      maskReg  <= 32'h0;
      reqQ     <= 32'h0;
      msgAddrR <= 64'h0;
      msgDataR <= 32'h0;
    end else begin
      enReg  <= enNext;
      mmeReg <= mmeNext;
      reqQ   <= qNext;
      if (cfgWrEn && cfgAddr == IDX_ALO) addrLo <= {wrWord[31:2], 2'b00};
      if (ADDR64 && cfgWrEn && cfgAddr == IDX_AHI) addrHi <= wrWord;
      if (cfgWrEn && cfgAddr == IDX_DATA) dataReg <= wrWord[15:0];
      if (MASK_EN && cfgWrEn && cfgAddr == IDX_MASK) maskReg <= wrWord & CAP_BITS;
      if (cmd.launch) begin
        msgAddrR <= {(ADDR64 ? addrHi : 32'h0), addrLo};
        msgDataR <= {16'h0, launchData};
      end
    end
  end

  assign msiEnable = enReg;
  assign eligible  = enReg ? VEC_CAP'(reqQ & ~maskEff) : '0;
  assign msgAddr   = msgAddrR;
  assign msgData   = msgDataR;

  assert_mask_not_sent_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.launch |-> !maskEff[cmd.vec]);
  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.launch |-> ((eligible & VEC_CAP'((32'h1 << cmd.vec) - 32'h1)) == '0));
  assert_queue_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    enReg |-> ((reqQ & ~vecCountMask(mmeReg)) == 32'h0));
  assert_mme_clamped_R5: assert property (@(posedge clk) disable iff (!rstN)
    enReg |-> (mmeReg <= MMC_VAL));
  assert_drop_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> ((reqQ & ~$past(reqQ)) == 32'h0));
endmodule

// File: rtl/msi_cap_sched.sv
module msi_cap_sched
  import msi_cap_pkg::*;
#(
  parameter int VEC_CAP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VEC_CAP-1:0] eligible,
  input  logic               msgReady,
  output logic               msgValid,
  output sendCmdT            cmd
);
  logic             validReg, anyElig;
  logic [VEC_W-1:0] pickVec;

  // Lowest-numbered eligible vector wins
  always_comb begin
    pickVec = '0;
    anyElig = 1'b0;
    for (int i = VEC_CAP - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pickVec = VEC_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  assign cmd.launch = anyElig && (!validReg || msgReady);
  assign cmd.vec    = pickVec;

  always_ff @(posedge clk) begin
    if (!rstN) validReg <= 1'b0;
    else if (cmd.launch) validReg <= 1'b1;
    else if (msgReady) validReg <= 1'b0;
  end

  assign msgValid = validReg;

  assert_valid_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (validReg && !msgReady) |=> validReg);
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int VEC_CAP = 4,
  parameter bit ADDR64  = 1'b1,
  parameter bit MASK_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgAddr,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        irqValid,
  input  logic [4:0]  irqVec,
  output logic        msgValid,
  input  logic        msgReady,
  output logic [63:0] msgAddr,
  output logic [31:0] msgData,
  input  logic        intxIn,
  output logic        intxOut
);
  sendCmdT            cmd;
  logic               msiEnable;
  logic [VEC_CAP-1:0] eligible;

  msi_cap_regs #(.VEC_CAP(VEC_CAP), .ADDR64(ADDR64), .MASK_EN(MASK_EN)) uRegs (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(irqValid), .reqVec(irqVec), .cmd(cmd), .msiEnable(msiEnable),
    .eligible(eligible), .msgAddr(msgAddr), .msgData(msgData)
  );

  msi_cap_sched #(.VEC_CAP(VEC_CAP)) uSched (
    .clk(clk), .rstN(rstN), .eligible(eligible), .msgReady(msgReady),
    .msgValid(msgValid), .cmd(cmd)
  );

  assign intxOut = intxIn & ~msiEnable;

  assert_msg_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> ($stable(msgAddr) && $stable(msgData)));
endmodule

// File: tb/msi_cap_ctrl_test.sv
module msi_cap_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = 3'd0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic        irqValid = 1'b0;
  logic [4:0]  irqVec = 5'd0;
  logic        msgValid;
  logic        msgReady = 1'b1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic        intxIn = 1'b1;
  logic        intxOut;

  int errors = 0;
  int checks = 0;
  int total = 0;
  logic [63:0] logAddr [64];
  logic [31:0] logData [64];

  always #10 clk = ~clk;

  msi_cap_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .irqValid(irqValid), .irqVec(irqVec), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData),
    .intxIn(intxIn), .intxOut(intxOut)
  );

  // Record every message that will be accepted at the next rising edge
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      logAddr[total % 64] = msgAddr;
      logData[total % 64] = msgData;
      total = total + 1;
    end
  end

  typedef struct packed {
    logic [2:0]  a;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
  } entryT;

  // Write then read back the same dword (R2, R3, R4, R5)
  localparam entryT TBL [9] = '{
    '{3'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFC},  // R3 low bits zero
    '{3'd2, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R3 high dword
    '{3'd2, 4'h1, 32'h0000_0055, 32'hDEAD_BE55},  // R3 byte lane
    '{3'd3, 4'hF, 32'hABCD_1234, 32'h0000_1234},  // R3 data 16 bits
    '{3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0000_000F},  // R4 mask width
    '{3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 pending read-only
    '{3'd0, 4'hF, 32'hFE7E_FFFF, 32'h01F4_0005},  // R2 read-only fields
    '{3'd0, 4'hF, 32'h0071_0000, 32'h01A5_0005},  // R5 clamp
    '{3'd0, 4'h4, 32'h0000_0000, 32'h0184_0005}   // R2 byte lane 2
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [2:0] a, logic [31:0] d, logic [3:0] be);
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d; cfgByteEn = be;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic cfgRead(logic [2:0] a, output logic [31:0] v);
    cfgAddr = a; #1; v = cfgRdData;
  endtask

  task automatic irq(logic [4:0] v);
    @(posedge clk); #1;
    irqValid = 1'b1; irqVec = v;
    @(posedge clk); #1;
    irqValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int base;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    cfgRead(3'd0, rd); chk("R1 ctrl", rd, 32'h0184_0005);
    for (int i = 1; i < 6; i++) begin
      cfgRead(3'(i), rd); chk("R1 zero dword", rd, 32'h0);
    end
    chk("R1 msgValid", msgValid, 1'b0);
    chk("R11 intx passes while disabled", intxOut, 1'b1);

    // Table walk
    for (int i = 0; i < 9; i++) begin
      cfgWrite(TBL[i].a, TBL[i].wd, TBL[i].be);
      cfgRead(TBL[i].a, rd);
      chk($sformatf("R2-R5 table entry %0d", i), rd, TBL[i].exp);
    end

    // Program message, enable with four vectors
    cfgWrite(3'd1, 32'hFEE0_0000, 4'hF);
    cfgWrite(3'd2, 32'h0000_0001, 4'hF);
    cfgWrite(3'd4, 32'h0, 4'hF);
    cfgWrite(3'd0, 32'h0021_0000, 4'hF);
    chk("R11 intx forced low when enabled", intxOut, 1'b0);

    // R6 vector merge
    base = total;
    irq(5'd3); idle(6);
    chk("R6 one message", total - base, 1);
    chk("R6 address", logAddr[base % 64], 64'h1_FEE0_0000);
    chk("R6 data merge", logData[base % 64], 32'h0000_1237);

    // R7 masked requests, duplicate
    base = total;
    cfgWrite(3'd4, 32'h3, 4'hF);
    irq(5'd1); irq(5'd1); irq(5'd0); idle(4);
    chk("R7 no message while masked", total - base, 0);
    cfgRead(3'd5, rd); chk("R7 pending bits", rd, 32'h3);
    // R8 replay on unmask, lowest first
    cfgWrite(3'd4, 32'h0, 4'hF); idle(6);
    chk("R8 two replayed", total - base, 2);
    chk("R8 first vector 0", logData[base % 64], 32'h0000_1234);
    chk("R8 then vector 1", logData[(base + 1) % 64], 32'h0000_1235);
    cfgRead(3'd5, rd); chk("R8 pending cleared", rd, 32'h0);

    // R12 back-pressure
    base = total;
    msgReady = 1'b0;
    irq(5'd2); idle(4);
    chk("R12 valid held", msgValid, 1'b1);
    chk("R12 data held", msgData, 32'h0000_1236);
    msgReady = 1'b1; idle(3);
    chk("R12 accepted once", total - base, 1);

    // R9 trim when vector count shrinks
    base = total;
    cfgWrite(3'd4, 32'hF, 4'hF);
    irq(5'd3); idle(2);
    cfgRead(3'd5, rd); chk("R9 pending before trim", rd, 32'h8);
    cfgWrite(3'd0, 32'h0011_0000, 4'hF);
    cfgRead(3'd5, rd); chk("R9 pending trimmed", rd, 32'h0);
    cfgWrite(3'd4, 32'h0, 4'hF); idle(5);
    chk("R9 nothing replayed", total - base, 0);

    // R6 single vector: data unchanged; R10 out-of-range vector dropped
    cfgWrite(3'd3, 32'h0000_5677, 4'hF);
    cfgWrite(3'd0, 32'h0001_0000, 4'hF);
    base = total;
    irq(5'd0); idle(5);
    chk("R6 single vector count", total - base, 1);
    chk("R6 single vector data", logData[base % 64], 32'h0000_5677);
    base = total;
    irq(5'd2); idle(5);
    chk("R10 vector beyond count dropped", total - base, 0);

    // R10 disabled requests dropped; R11 intx follows input
    cfgWrite(3'd0, 32'h0, 4'hF);
    chk("R11 intx restored", intxOut, 1'b1);
    base = total;
    irq(5'd0); idle(4);
    cfgWrite(3'd0, 32'h0001_0000, 4'hF); idle(5);
    chk("R10 disabled request dropped", total - base, 0);

    summary();
  end
endmodule